// File: doc/BRIEF.md
# Sector-Quota Cache Victim Selector

This block chooses which way of a set-associative cache is replaced on a miss, when the ways of every set are shared by two sectors that software picks per access. Sector 0 is the default home of instruction fetches and ordinary data. Sector 1 takes only data accesses that software tags for it. Each line carries a sector bit. A configuration input gives the number of ways in each set that sector 1 may occupy, and sector 0 may occupy the rest. On every miss the block steers the replacement so that the set drifts toward that split. Lookups and hits behave as in a plain cache; the sectors only affect the choice of victim.

For every set the block keeps each way's valid bit, its sector bit and a complete recency order of the ways. A lookup strobe carries the set index, a hit flag, the hit way and the requester's sector. A hit makes the hit way the most recent. A miss picks a victim, fills it at once with the requester's sector, marks it valid and most recent, and reports the victim way one cycle later. Tags, data arrays and coherency are handled elsewhere.

Top module: `sectorQuotaRepl`

## Requirements
- R1: After reset every way of every set is invalid with sector 0, `victimValid` is 0, and the recency order of each set has way 0 as most recent and way NUM_WAYS-1 as oldest.
- R2: On a miss to a set that holds an invalid way, the victim is the invalid way with the lowest index.
- R3: On a miss to a full set, if the requester's sector holds fewer lines than its quota, the victim is the oldest line of the other sector. The sector-1 quota is the clamped `sector1Quota` and the sector-0 quota is NUM_WAYS minus it.
- R4: On a miss to a full set, if the requester's sector holds at least as many lines as its quota, the victim is the oldest line of the requester's own sector.
- R5: If the sector chosen by R3 or R4 has no line in the full set, the victim is the oldest line of the set.
- R6: A filled way becomes valid, takes the requester's sector bit (`reqSector`, 0 or 1) and becomes most recent. A hit makes the hit way most recent and leaves its valid and sector bits unchanged.
- R7: A `sector1Quota` above NUM_WAYS acts as NUM_WAYS.
- R8: `victimValid` is 1 in exactly the cycle after a lookup with `lookupValid`=1 and `lookupHit`=0, and 0 otherwise. `victimWay` then holds the victim, which is below NUM_WAYS.
- R9: A lookup changes only the state of the set it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup strobe, one cycle per access |
| lookupHit | input | 1 | 1: the lookup hit `hitWay`; 0: miss, a fill follows |
| lookupIdx | input | IDX_W | Set index of the lookup |
| hitWay | input | WAY_W | Way that hit (used when `lookupHit`=1) |
| reqSector | input | 1 | Sector of the requester (0 or 1) |
| sector1Quota | input | QW | Number of ways per set given to sector 1 |
| victimWay | output | WAY_W | Way replaced by the previous miss |
| victimValid | output | 1 | `victimWay` is valid this cycle |

## Verification
The assertions take for granted that a hit names a way below NUM_WAYS that holds a valid line of the indexed set, and that the index is below NUM_SETS. The stimulus keeps within this by taking every hit way from the bench's own record of the valid lines of that set and by using only a few indices. A small group of sets is therefore filled quickly, so that most misses land in full sets and exercise the quota rules under random sectors and quotas, including quotas above the way count.

// File: rtl/sqrPkg.sv
package sqrPkg;
  // Update strobes from control to the state arrays
  typedef struct packed {
    logic touch;      // make the update way most recent
    logic fill;       // set valid and load the sector bit
    logic sectorBit;  // sector written on a fill
  } sqrStrobe_t;
endpackage

// File: rtl/sqrDatapath.sv
module sqrDatapath
  import sqrPkg::*;
#(
  parameter int NUM_WAYS = 10,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  input  sqrStrobe_t       stb,
  input  logic [WAY_W-1:0] updWay,
  output logic [NUM_WAYS-1:0] setValid,
  output logic [NUM_WAYS-1:0] setSector,
  output logic [WAY_W-1:0]    setRank [NUM_WAYS]
);

  logic [NUM_WAYS-1:0] validArr  [NUM_SETS];
  logic [NUM_WAYS-1:0] sectorArr [NUM_SETS];
  logic [WAY_W-1:0]    rankArr   [NUM_SETS][NUM_WAYS];

  assign setValid  = validArr[rdIdx];
  assign setSector = sectorArr[rdIdx];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rankRd
    assign setRank[w] = rankArr[rdIdx][w];
  end

  // The update always targets the set being read (rdIdx)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validArr[s]  <= '0;
        sectorArr[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
          rankArr[s][w] <= WAY_W'(w);
        end
      end
    end else if (stb.touch) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (rdIdx == IDX_W'(s)) begin
          if (stb.fill) begin
            validArr[s][updWay]  <= 1'b1;
            sectorArr[s][updWay] <= stb.sectorBit;
          end
          for (int w = 0; w < NUM_WAYS; w++) begin
            if (updWay == WAY_W'(w)) begin
              rankArr[s][w] <= '0;
            end else if (rankArr[s][w] < rankArr[s][updWay]) begin
              rankArr[s][w] <= rankArr[s][w] + WAY_W'(1);
            end
          end
        end
      end
    end
  end

  // R6
  fill_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.touch && stb.fill) |->
      (validArr[$past(rdIdx)][$past(updWay)] &&
       sectorArr[$past(rdIdx)][$past(updWay)] == $past(stb.sectorBit)));

  // R6
  hit_sector_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.touch && !stb.fill) |->
      (sectorArr[$past(rdIdx)][$past(updWay)] == $past(sectorArr[rdIdx][updWay]) &&
       validArr[$past(rdIdx)][$past(updWay)] == $past(validArr[rdIdx][updWay])));

  // R6
  touch_mru_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.touch) |-> rankArr[$past(rdIdx)][$past(updWay)] == '0);

endmodule

// File: rtl/sqrControl.sv
module sqrControl
  import sqrPkg::*;
#(
  parameter int NUM_WAYS = 10,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int QW = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic                lookupHit,
  input  logic [WAY_W-1:0]    hitWay,
  input  logic                reqSector,
  input  logic [QW-1:0]       sector1Quota,
  input  logic [NUM_WAYS-1:0] setValid,
  input  logic [NUM_WAYS-1:0] setSector,
  input  logic [WAY_W-1:0]    setRank [NUM_WAYS],
  output sqrStrobe_t          stb,
  output logic [WAY_W-1:0]    updWay,
  output logic [WAY_W-1:0]    victimWay,
  output logic                victimValid
);

  logic             missNow;
  logic             anyFree;
  logic [WAY_W-1:0] freeWay;
  logic [QW-1:0]    cnt1, quota1, ownCnt, ownQuota;
  logic             targetSec;
  logic             tgtFound;
  logic [WAY_W-1:0] tgtWay, tgtRank, allWay, allRank;
  logic [WAY_W-1:0] pickWay;

  assign missNow = lookupValid && !lookupHit;

  always_comb begin
    anyFree = 1'b0;
    freeWay = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!setValid[w]) begin
        anyFree = 1'b1;
        freeWay = WAY_W'(w);
      end
    end

    cnt1 = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (setValid[w] && setSector[w]) cnt1 = cnt1 + QW'(1);
    end

    quota1   = (sector1Quota > QW'(NUM_WAYS)) ? QW'(NUM_WAYS) : sector1Quota;
    ownCnt   = reqSector ? cnt1 : QW'(NUM_WAYS) - cnt1;
    ownQuota = reqSector ? quota1 : QW'(NUM_WAYS) - quota1;
    targetSec = (ownCnt < ownQuota) ? ~reqSector : reqSector;

    tgtFound = 1'b0;
    tgtWay   = '0;
    tgtRank  = '0;
    allWay   = '0;
    allRank  = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (setRank[w] >= allRank) begin
        allRank = setRank[w];
        allWay  = WAY_W'(w);
      end
      if (setSector[w] == targetSec && (!tgtFound || setRank[w] > tgtRank)) begin
        tgtFound = 1'b1;
        tgtRank  = setRank[w];
        tgtWay   = WAY_W'(w);
      end
    end

    pickWay = anyFree ? freeWay : (tgtFound ? tgtWay : allWay);
  end

  always_comb begin
    stb.touch     = lookupValid;
    stb.fill      = missNow;
    stb.sectorBit = reqSector;
    updWay        = missNow ? pickWay : hitWay;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
    end else begin
      victimValid <= missNow;
      if (missNow) victimWay <= pickWay;
    end
  end

  // R8
  victim_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid == $past(lookupValid && !lookupHit));

  // R8
  way_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> victimWay < WAY_W'(NUM_WAYS));

  // R2
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missNow && !(&setValid)) |-> !setValid[pickWay]);

  // R4
  sector_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missNow && (&setValid) && tgtFound) |-> setSector[pickWay] == targetSec);

endmodule

// File: rtl/sectorQuotaRepl.sv
module sectorQuotaRepl
  import sqrPkg::*;
#(
  parameter int NUM_WAYS = 10,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int QW = $clog2(NUM_WAYS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupHit,
  input  logic [IDX_W-1:0] lookupIdx,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             reqSector,
  input  logic [QW-1:0]    sector1Quota,
  output logic [WAY_W-1:0] victimWay,
  output logic             victimValid
);

  sqrStrobe_t          stb;
  logic [WAY_W-1:0]    updWay;
  logic [NUM_WAYS-1:0] setValid;
  logic [NUM_WAYS-1:0] setSector;
  logic [WAY_W-1:0]    setRank [NUM_WAYS];

  sqrControl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupHit(lookupHit), .hitWay(hitWay),
    .reqSector(reqSector), .sector1Quota(sector1Quota),
    .setValid(setValid), .setSector(setSector), .setRank(setRank),
    .stb(stb), .updWay(updWay),
    .victimWay(victimWay), .victimValid(victimValid)
  );

  sqrDatapath #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_data (
    .clk(clk), .rstN(rstN),
    .rdIdx(lookupIdx), .stb(stb), .updWay(updWay),
    .setValid(setValid), .setSector(setSector), .setRank(setRank)
  );

endmodule

// File: tb/sim_sectorQuotaRepl.sv
module sim_sectorQuotaRepl;
  localparam int NW = 10;
  localparam int NS = 16;
  localparam int WW = $clog2(NW);
  localparam int IW = $clog2(NS);
  localparam int QW = $clog2(NW + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rstN;
  logic          lookupValid, lookupHit, reqSector;
  logic [IW-1:0] lookupIdx;
  logic [WW-1:0] hitWay;
  logic [QW-1:0] sector1Quota;
  logic [WW-1:0] victimWay;
  logic          victimValid;

  sectorQuotaRepl #(.NUM_WAYS(NW), .NUM_SETS(NS)) u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupHit(lookupHit),
    .lookupIdx(lookupIdx), .hitWay(hitWay), .reqSector(reqSector),
    .sector1Quota(sector1Quota), .victimWay(victimWay), .victimValid(victimValid)
  );

  int checks = 0;
  int fails = 0;
  bit mValid [NS][NW];
  bit mSec   [NS][NW];
  int mRank  [NS][NW];

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int expVictim(int idx, bit sec, int quota);
    int q1, cnt1, ownCnt, ownQ, best, bestRank, all, allRank;
    bit tgt;
    for (int w = 0; w < NW; w++) if (!mValid[idx][w]) return w;  // R2
    q1 = (quota > NW) ? NW : quota;                              // R7
    cnt1 = 0;
    for (int w = 0; w < NW; w++) if (mSec[idx][w]) cnt1++;
    ownCnt = sec ? cnt1 : NW - cnt1;
    ownQ   = sec ? q1 : NW - q1;
    tgt = (ownCnt < ownQ) ? !sec : sec;                          // R3 / R4
    best = -1; bestRank = -1; all = 0; allRank = -1;
    for (int w = 0; w < NW; w++) begin
      if (mRank[idx][w] > allRank) begin allRank = mRank[idx][w]; all = w; end
      if (mSec[idx][w] == tgt && mRank[idx][w] > bestRank) begin
        bestRank = mRank[idx][w]; best = w;
      end
    end
    return (best >= 0) ? best : all;                             // R5
  endfunction

  task automatic touchModel(int idx, int way);
    int r = mRank[idx][way];
    for (int w = 0; w < NW; w++) if (mRank[idx][w] < r) mRank[idx][w]++;
    mRank[idx][way] = 0;
  endtask

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic doMiss(string tag, int idx, bit sec, int quota, int expWay = -1);
    int e = expVictim(idx, sec, quota);
    lookupValid = 1'b1; lookupHit = 1'b0; lookupIdx = IW'(idx);
    reqSector = sec; sector1Quota = QW'(quota); hitWay = '0;
    if (expWay >= 0) checkVal(tag, "model", e, expWay);
    touchModel(idx, e);
    mValid[idx][e] = 1'b1;
    mSec[idx][e] = sec;
    @(negedge clk);
    lookupValid = 1'b0;
    checkVal(tag, "victimValid", int'(victimValid), 1);
    checkVal(tag, "victimWay", int'(victimWay), e);
  endtask

  task automatic doHit(string tag, int idx, int way);
    lookupValid = 1'b1; lookupHit = 1'b1; lookupIdx = IW'(idx);
    hitWay = WW'(way); reqSector = 1'b1;
    touchModel(idx, way);
    @(negedge clk);
    lookupValid = 1'b0;
    checkVal(tag, "victimValid after hit", int'(victimValid), 0);
  endtask

  task automatic fillSet(int idx, int n1);
    for (int w = 0; w < NW; w++) doMiss("R2", idx, (w >= NW - n1), 0, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mValid[s][w] = 1'b0; mSec[s][w] = 1'b0; mRank[s][w] = w;
      end
    rstN = 1'b0; lookupValid = 1'b0; lookupHit = 1'b0; lookupIdx = '0;
    hitWay = '0; reqSector = 1'b0; sector1Quota = '0;
    repeat (3) @(negedge clk);
    checkVal("R1", "victimValid in reset", int'(victimValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "victimValid after reset", int'(victimValid), 0);

    // R1 first miss lands in way 0; R2 fills ways in index order
    fillSet(1, 0);
    // R3 sector 1 under quota 3 takes oldest sector-0 line
    doMiss("R3", 1, 1'b1, 3, 0);
    doMiss("R3", 1, 1'b1, 3, 1);
    doMiss("R3", 1, 1'b1, 3, 2);
    // R4 sector 1 at quota recycles its own oldest line
    doMiss("R4", 1, 1'b1, 3, 0);
    // R4 sector 0 at quota 7 recycles its own oldest line
    doMiss("R4", 1, 1'b0, 3, 3);
    // R6 a hit keeps sector, refreshes age: way 1 becomes newest
    doHit("R6", 1, 1);
    doMiss("R6", 1, 1'b1, 3, 2);
    // R5 own sector empty with quota 0: oldest overall
    fillSet(2, 0);
    doMiss("R5", 2, 1'b1, 0, 0);
    // R7 quota 15 acts as 10: sector 0 quota is 0, so own oldest
    fillSet(3, 5);
    doMiss("R7", 3, 1'b0, 15, 0);
    doMiss("R7", 3, 1'b1, 15, 1);
    // R9 set 4 untouched by the work above: still empty, way 0 first
    doMiss("R9", 4, 1'b1, 5, 0);

    // Random mix over a few sets
    void'($urandom(32'd12345));
    for (int i = 0; i < 3000; i++) begin
      int idx = 8 + int'($urandom_range(0, 3));
      int nValid = 0;
      for (int w = 0; w < NW; w++) if (mValid[idx][w]) nValid++;
      if (nValid > 0 && $urandom_range(0, 9) < 4) begin
        int pick = int'($urandom_range(0, nValid - 1));
        int way = 0;
        for (int w = 0; w < NW; w++) if (mValid[idx][w]) begin
          if (pick == 0) way = w;
          pick--;
        end
        doHit("R6", idx, way);
      end else if ($urandom_range(0, 9) == 0) begin
        @(negedge clk);
        checkVal("R8", "victimValid idle", int'(victimValid), 0);
      end else begin
        doMiss("R3/R4", idx, bit'($urandom_range(0, 1)), int'($urandom_range(0, 12)));
      end
    end

    // R9 set 4 still holds only the one line filled earlier
    doMiss("R9", 4, 1'b0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule